// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Engine

This block sits behind the serial-bus slave controller of a small nonvolatile memory. The controller hands it a 13-bit start address when a write command's address phase completes. It then passes each completed data byte, and finally a commit strobe when the stop condition arrives. The block stores the bytes in a 32-entry page buffer. The upper 8 address bits select the page and stay fixed. The low 5 bits advance for each byte and wrap inside the page with no carry.

On commit the block enters a single internal write cycle. Its length in clock ticks is programmable and does not depend on how many bytes were sent. At the start of the cycle the block replays the buffered bytes to a byte-wide memory write port, one offset per clock. While the cycle runs the busy flag is high and every command input is ignored.

A write-protect input and a low-voltage inhibit input can veto the write. Write protect is ignored during the address phase. It takes effect from the clock that delivers the first data byte. From there to the end of the cycle, a high level on write protect discards the pending write or cuts the running cycle short. The low-voltage inhibit stops a cycle from starting and ends a cycle that is running.

Top module: `page_commit_engine`

## Requirements
- R1: A write lands at address {upper 8 bits of the start address, (start offset + n) mod 32} for the n-th data byte. Starting at offset 1Eh gives offsets 1Eh, 1Fh, 00h, 01h, and the upper 8 bits never change.
- R2: When more than 32 bytes are received, later bytes replace earlier ones at the same wrapped offset. Only offsets that received a byte are written.
- R3: A commit with no completed data byte since the last address load starts no cycle and drops the pending command.
- R4: An accepted commit raises busy_o on the next clock. busy_o then stays high for exactly cycle_len_i clocks, whether one byte or a full page was sent (a value of 0 acts as 1).
- R5: While busy_o is high, addr_load_i, data_valid_i and commit_i have no effect.
- R6: wp_i is ignored from the address load until the clock that delivers the first data byte.
- R7: If wp_i is high in any clock from the first data byte up to and including the commit, the pending write is discarded. No cycle starts and nothing is written.
- R8: wp_i high during a cycle suppresses the write in that clock and drops busy_o on the next clock. No further writes follow.
- R9: lv_inhibit_i high at commit prevents the cycle. lv_inhibit_i high during a cycle ends it in the same way as R8.
- R10: Writes are issued in the first 32 clocks of the cycle. The clock k after the cycle starts covers offset (start offset + k) mod 32, and it writes only if that offset holds a byte, so an empty offset still uses up its clock.
- R11: After reset busy_o and mem_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Start-address strobe; opens a new write command |
| addr_i | input | 13 | Start address (page in [12:5], offset in [4:0]) |
| data_valid_i | input | 1 | One completed data byte, pulsed on the clock where its last bit is captured |
| data_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop-condition strobe |
| wp_i | input | 1 | Write protect, active high |
| lv_inhibit_i | input | 1 | Low-supply inhibit, active high |
| cycle_len_i | input | 24 | Write cycle length in clocks |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 13 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench goes after the wrap from offset 1Fh to 00h. A design that carried into the page bits would write to the next page. It drives 34 bytes into one page, where a buffer without per-offset overwrite would emit more than 32 writes or keep stale bytes. It also runs partial pages, where a design without valid bits would write offsets that never received data. It checks write protect against its window. If wp_i were honoured too early, a legal write raised during the address phase would be lost. If it were honoured too late, protected data would reach the array. A cancel mid-cycle must stop the writes and drop busy at once; a design that waited for the full cycle would show too many busy clocks. It also sends a complete command during busy, which a design that leaked it would commit.

// File: rtl/pce_pkg.sv
`timescale 1ns/1ps
package pce_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DATA  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;
endpackage

// File: rtl/page_buffer.sv
`timescale 1ns/1ps
module page_buffer #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 8,
  localparam int PAGE   = 1 << OFF_W,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  start_off_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  start_q, wr_off_q;
  logic [PAGE-1:0]   valid_q;
  logic [DATA_W-1:0] mem_q [PAGE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      start_q  <= '0;
      wr_off_q <= '0;
    end else if (load_i) begin
      page_q   <= addr_i[ADDR_W-1:OFF_W];
      start_q  <= addr_i[OFF_W-1:0];
      wr_off_q <= addr_i[OFF_W-1:0];
    end else if (push_i) begin
      wr_off_q <= wr_off_q + OFF_W'(1);  // wraps inside the page
    end
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_entry
    logic hit;
    assign hit = push_i && !load_i && (wr_off_q == OFF_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        mem_q[i]   <= '0;
      end else begin
        if (load_i || clear_i) valid_q[i] <= 1'b0;
        else if (hit)          valid_q[i] <= 1'b1;
        if (hit) mem_q[i] <= data_i;
      end
    end
  end

  assign page_o      = page_q;
  assign start_off_o = start_q;
  assign rd_valid_o  = valid_q[rd_off_i];
  assign rd_data_o   = mem_q[rd_off_i];

  assert_push_marks_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !load_i && !clear_i) |=> valid_q[$past(wr_off_q)]);
endmodule

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
module cycle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             run_o,
  output logic             last_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q, len_q;

  assign last_o = run_q && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, len_q});
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      len_q <= len_i;
    end else if (run_q) begin
      if (kill_i || last_o) run_q <= 1'b0;
      else                  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_count_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && len_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/write_sequencer.sv
`timescale 1ns/1ps
module write_sequencer #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  // extra top bit marks the page as fully scanned
  logic [OFF_W:0] scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       scan_q <= '0;
    else if (start_i)                  scan_q <= '0;
    else if (run_i && !scan_q[OFF_W])  scan_q <= scan_q + (OFF_W+1)'(1);
  end

  assign rd_off_o    = start_off_i + scan_q[OFF_W-1:0];
  assign mem_we_o    = run_i && !scan_q[OFF_W] && rd_valid_i && !hold_i;
  assign mem_addr_o  = {page_i, rd_off_o};
  assign mem_wdata_o = rd_data_i;

  assert_write_inside_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (run_i && !start_i));
  assert_no_write_under_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !hold_i);
endmodule

// File: rtl/page_commit_engine.sv
`timescale 1ns/1ps
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 24,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              wp_i,
  input  logic              lv_inhibit_i,
  input  logic [CNT_W-1:0]  cycle_len_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  phase_e phase_q, phase_d;
  logic buf_load, buf_push, buf_clear, t_start, t_run, t_last, hold;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  start_off, rd_off;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;

  assign hold = wp_i || lv_inhibit_i;

  always_comb begin
    phase_d   = phase_q;
    buf_load  = 1'b0;
    buf_push  = 1'b0;
    buf_clear = 1'b0;
    t_start   = 1'b0;
    if (phase_q == PH_WRITE) begin
      if (t_last || hold) begin
        phase_d   = PH_IDLE;
        buf_clear = 1'b1;
      end
    end else if (addr_load_i) begin
      buf_load = 1'b1;
      phase_d  = PH_ADDR;
    end else if (data_valid_i && phase_q != PH_IDLE) begin
      buf_push = 1'b1;
      if (wp_i) begin  // protect window opens on the first byte's capture clock
        buf_clear = 1'b1;
        phase_d   = PH_IDLE;
      end else begin
        phase_d   = PH_DATA;
      end
    end else if (phase_q == PH_DATA && wp_i) begin
      buf_clear = 1'b1;
      phase_d   = PH_IDLE;
    end else if (commit_i) begin
      if (phase_q == PH_DATA && !lv_inhibit_i) begin
        t_start = 1'b1;
        phase_d = PH_WRITE;
      end else begin
        buf_clear = 1'b1;
        phase_d   = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign busy_o = (phase_q == PH_WRITE);

  page_buffer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i     (buf_load),
    .addr_i     (addr_i),
    .push_i     (buf_push),
    .data_i     (data_i),
    .clear_i    (buf_clear),
    .rd_off_i   (rd_off),
    .page_o     (page),
    .start_off_o(start_off),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .start_i(t_start),
    .kill_i (hold),
    .len_i  (cycle_len_i),
    .run_o  (t_run),
    .last_o (t_last)
  );

  write_sequencer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (t_start),
    .run_i      (t_run),
    .hold_i     (hold),
    .page_i     (page),
    .start_off_i(start_off),
    .rd_valid_i (rd_valid),
    .rd_data_i  (rd_data),
    .rd_off_o   (rd_off),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  assert_phase_matches_timer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == t_run);
  assert_page_frozen_in_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && addr_load_i) |=> $stable(page));
  assert_hold_ends_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wp_i) |=> !busy_o);
  assert_low_supply_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && lv_inhibit_i) |=> !busy_o);
  assert_protect_discards_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && wp_i) |=> !busy_o);
  assert_empty_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_DATA && !busy_o) |=> !busy_o);
endmodule

// File: tb/sim_page_commit_engine.sv
`timescale 1ns/1ps
module sim_page_commit_engine;
  localparam int LEN = 48;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        addr_load_i = 0, data_valid_i = 0, commit_i = 0, wp_i = 0, lv_inhibit_i = 0;
  logic [12:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [23:0] cycle_len_i = 24'(LEN);
  logic        busy_o, mem_we_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  always #10 clk_i = ~clk_i;

  page_commit_engine u0 (.*);

  int n_vec = 0, n_fail = 0, bc = 0, wc = 0;
  bit done = 0;
  logic [7:0] shadow [int];
  int wlog [$];

  // behavioural reference model
  int m_ph, m_page, m_start, m_woff, m_tick, m_scan, m_len;
  bit m_valid [32];
  int m_data [32];

  task automatic m_clear();
    for (int i = 0; i < 32; i++) m_valid[i] = 0;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_page = 0; m_start = 0; m_woff = 0; m_tick = 0; m_scan = 32; m_len = 0;
      m_clear();
    end else if (m_ph == 3) begin
      if (wp_i || lv_inhibit_i || m_tick + 1 >= m_len) begin m_ph = 0; m_clear(); end
      else m_tick++;
      if (m_scan < 32) m_scan++;
    end else if (addr_load_i) begin
      m_ph = 1; m_page = int'(addr_i) / 32; m_start = int'(addr_i) % 32; m_woff = m_start; m_clear();
    end else if (data_valid_i && m_ph != 0) begin
      m_data[m_woff] = int'(data_i); m_valid[m_woff] = 1; m_woff = (m_woff + 1) % 32;
      if (wp_i) begin m_ph = 0; m_clear(); end else m_ph = 2;
    end else if (m_ph == 2 && wp_i) begin
      m_ph = 0; m_clear();
    end else if (commit_i) begin
      if (m_ph == 2 && !lv_inhibit_i) begin m_ph = 3; m_tick = 0; m_scan = 0; m_len = LEN; end
      else begin m_ph = 0; m_clear(); end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison and write capture, away from the active edge
  always @(negedge clk_i) if (rst_ni) begin
    bit e_busy, e_we;
    int off;
    e_busy = (m_ph == 3);
    off = (m_start + m_scan) % 32;
    e_we = e_busy && m_scan < 32 && m_valid[off] && !(wp_i || lv_inhibit_i);
    chk(busy_o == e_busy, "R4 busy", int'(busy_o), int'(e_busy));
    chk(mem_we_o == e_we, "R10 we", int'(mem_we_o), int'(e_we));
    if (e_we && mem_we_o) begin
      chk(int'(mem_addr_o) == m_page * 32 + off, "R1 addr", int'(mem_addr_o), m_page * 32 + off);
      chk(int'(mem_wdata_o) == m_data[off], "R2 data", int'(mem_wdata_o), m_data[off]);
    end
    if (busy_o) bc++;
    if (mem_we_o) begin wc++; shadow[int'(mem_addr_o)] = mem_wdata_o; wlog.push_back(int'(mem_addr_o)); end
  end

  task automatic step(); @(posedge clk_i); #1; endtask
  task automatic load(int a); addr_load_i = 1; addr_i = 13'(a); step(); addr_load_i = 0; endtask
  task automatic push(int d); data_valid_i = 1; data_i = 8'(d); step(); data_valid_i = 0; endtask
  task automatic commit(); commit_i = 1; step(); commit_i = 0; endtask
  task automatic clr(); bc = 0; wc = 0; wlog.delete(); endtask
  task automatic settle(); int g = 0; while (busy_o && g < 400) begin step(); g++; end repeat (3) step(); endtask

  initial begin
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    chk(busy_o == 0, "R11 busy", int'(busy_o), 0);
    chk(mem_we_o == 0, "R11 we", int'(mem_we_o), 0);
    @(posedge clk_i); #1 rst_ni = 1;
    step();

    // single byte
    clr(); load(13'h0123); push(8'hA5); commit(); settle();
    chk(wc == 1, "R1 count", wc, 1);
    chk(shadow.exists(13'h0123) && shadow[13'h0123] == 8'hA5, "R1 byte", int'(shadow.exists(13'h0123)), 1);
    chk(bc == LEN, "R4 single", bc, LEN);

    // wrap from 1Eh
    clr(); load(13'h0A5E); push(8'h11); push(8'h22); push(8'h33); push(8'h44); commit(); settle();
    chk(wc == 4, "R1 wrap count", wc, 4);
    chk(shadow[13'h0A40] == 8'h33 && shadow[13'h0A41] == 8'h44, "R1 wrap", int'(shadow[13'h0A40]), 8'h33);
    chk(!shadow.exists(13'h0A60), "R1 no carry", int'(shadow.exists(13'h0A60)), 0);
    chk(bc == LEN, "R4 page", bc, LEN);
    chk(wlog.size() == 4 && wlog[0] == 13'h0A5E && wlog[2] == 13'h0A40, "R10 order", wlog[0], 13'h0A5E);

    // overflow past 32 bytes
    clr(); load(13'h1F60); for (int i = 0; i < 34; i++) push(8'h80 + i); commit(); settle();
    chk(wc == 32, "R2 overflow count", wc, 32);
    chk(shadow[13'h1F60] == 8'hA0 && shadow[13'h1F61] == 8'hA1, "R2 overwrite", int'(shadow[13'h1F60]), 8'hA0);
    chk(shadow[13'h1F62] == 8'h82, "R2 kept", int'(shadow[13'h1F62]), 8'h82);

    // partial page
    clr(); load(13'h0305); push(1); push(2); push(3); commit(); settle();
    chk(wc == 3, "R2 partial", wc, 3);
    chk(bc == LEN, "R4 partial", bc, LEN);

    // empty commits
    clr(); load(13'h0400); commit(); repeat (4) step(); commit(); repeat (4) step();
    chk(bc == 0 && wc == 0, "R3 empty", bc + wc, 0);

    // commands during busy
    clr(); load(13'h0500); push(8'h5A); commit();
    load(13'h0600); push(8'h66); commit(); settle(); repeat (60) step();
    chk(wc == 1 && bc == LEN, "R5 ignored", wc * 1000 + bc, 1000 + LEN);
    chk(!shadow.exists(13'h0600), "R5 no leak", int'(shadow.exists(13'h0600)), 0);

    // protect during address phase only
    clr(); wp_i = 1; load(13'h0700); wp_i = 0; push(8'h77); commit(); settle();
    chk(wc == 1 && shadow[13'h0700] == 8'h77, "R6 early wp", wc, 1);

    // protect after first byte
    clr(); load(13'h0800); push(8'h88); wp_i = 1; step(); wp_i = 0; commit(); repeat (6) step();
    chk(wc == 0 && bc == 0, "R7 cancel", wc + bc, 0);
    chk(!shadow.exists(13'h0800), "R7 untouched", int'(shadow.exists(13'h0800)), 0);

    // protect mid cycle
    clr(); load(13'h0900); for (int i = 0; i < 8; i++) push(8'h90 + i); commit();
    step(); step(); step(); wp_i = 1; step();
    chk(busy_o == 0, "R8 drop", int'(busy_o), 0);
    wp_i = 0; settle();
    chk(wc == 3 && bc == 4, "R8 cut", wc * 100 + bc, 304);
    chk(!shadow.exists(13'h0903) && !shadow.exists(13'h0907), "R8 untouched", int'(shadow.exists(13'h0903)), 0);

    // low supply
    clr(); load(13'h0A00); push(8'hAA); lv_inhibit_i = 1; commit(); lv_inhibit_i = 0; repeat (4) step();
    chk(wc == 0 && bc == 0, "R9 at commit", wc + bc, 0);
    clr(); load(13'h0B00); push(8'hB0); push(8'hB1); commit(); repeat (10) step();
    lv_inhibit_i = 1; step();
    chk(busy_o == 0, "R9 drop", int'(busy_o), 0);
    lv_inhibit_i = 0; settle();
    chk(wc == 2 && bc == 11, "R9 cut", wc * 100 + bc, 211);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule